// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller collects interrupt requests from on-chip peripheral sources and from external request pins. It drives two lines toward a processor core. The normal request line `irq_o` is fed by every internal source and every external request pin, and each of those sources has its own mask bit, trigger mode and 3-bit priority. The fast request line `fiq_o` is a synchronised copy of one dedicated external pin. No other source can reach that line.

Software services the normal line through a small register port. A read of the vector register returns the handler address programmed for the winning source. That read also acknowledges the interrupt: it clears the source's edge latch and pushes the winner's priority onto an internal eight-entry level stack. While the stack is not empty, only a source with a strictly higher priority than the top entry raises `irq_o` again, so handlers nest by priority. A write to the end-of-interrupt register pops the stack.

The register port has no back-pressure. An access completes in the cycle it is presented. Read data is combinational from the address while `bus_re_i` is high, and the side effects of a read or a write take place at the closing clock edge. The external pins and the fast pin pass through a two-stage synchroniser. The internal sources are taken as synchronous to `clk`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, all sources are masked (mask register at 0x02 reads 0), and the level register at 0x07 reads 0.
- R2: Writing ones to 0x00 sets mask bits and writing ones to 0x01 clears them; zero bits leave the mask unchanged. A source whose mask bit is 0 never raises `irq_o`, but it still shows in the pending register at 0x03 (bit i = source i).
- R3: `fiq_o` follows `fast_req_i` two clock edges later and is unaffected by any source, mask or configuration.
- R4: An internal source (numbers 0 to N_INT-1) is configured at 0x10+i: bit 3 set selects rising-edge trigger and bit 3 clear selects active-high level. Bit 4 has no effect on an internal source.
- R5: An external source (numbers N_INT and up, pin k = source N_INT+k) uses bit 3 for edge/level and bit 4 for inversion, which gives rising edge (edge, no invert), falling edge (edge, invert), high level (level, no invert) and low level (level, invert).
- R6: Bits [2:0] of the configuration word hold the priority, where 7 is the highest. Among pending, unmasked sources the highest priority wins, and on a tie the lowest source number wins.
- R7: A read of 0x04 while `irq_o` is high returns the 32-bit handler address stored at 0x20+i for the winner. That read also clears the winner's edge latch and pushes its priority onto the level stack. The level register holds the depth in bits [3:0] and the top priority in bits [6:4].
- R8: A level-sensitive source stays pending after acknowledge for as long as its input remains active.
- R9: While the stack is not empty, `irq_o` is raised only when the winner's priority is strictly greater than the top of the stack.
- R10: A write to 0x05 pops one stack entry. On an empty stack that write has no effect. The stack changes only on an acknowledge or an end-of-interrupt.
- R11: A read of 0x04 while `irq_o` is low returns the spurious vector held at 0x06 and leaves the stack unchanged.
- R12: The stack holds at most eight entries. After eight nested acknowledges of priorities 0 through 7, the level register reads 0x78 and further vector reads return the spurious vector.
- R13: Read data is valid in the same cycle as `bus_re_i`, without wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src_i | input | N_INT | Internal peripheral request inputs, synchronous |
| ext_irq_i | input | N_EXT | External request pins, asynchronous |
| fast_req_i | input | 1 | Dedicated external fast request pin, active high |
| bus_addr_i | input | 6 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (vector read has side effects) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while `bus_re_i` is high |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |

## Verification
The hardest state to reach is a completely full level stack. It can only be built by acknowledging sources one at a time in strictly rising priority order. The bench therefore sets every source to level-high with a priority equal to its number. It then raises the sources one by one, from lowest to highest, and reads the vector after each one. This gives eight nested entries and brings the block to the point where no request can preempt. Falling-edge and low-level external modes are reached by first parking the pin at the inactive level and waiting out the synchroniser before the configuration is written, so that no false event is latched.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int PRIO_W   = 3;
  localparam int N_LEVELS = 1 << PRIO_W;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int DEPTH_W  = 4;

  typedef logic [PRIO_W-1:0] prio_t;

  // Per-source configuration word, bits [4:0] of the config register
  typedef struct packed {
    logic  invert;     // bit 4: active-low / falling (external only)
    logic  edge_mode;  // bit 3: 1 edge latch, 0 level
    prio_t prio;       // bits [2:0]
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);

  localparam logic [ADDR_W-1:0] A_MASK_SET = 6'h00;
  localparam logic [ADDR_W-1:0] A_MASK_CLR = 6'h01;
  localparam logic [ADDR_W-1:0] A_MASK     = 6'h02;
  localparam logic [ADDR_W-1:0] A_PEND     = 6'h03;
  localparam logic [ADDR_W-1:0] A_VEC      = 6'h04;
  localparam logic [ADDR_W-1:0] A_EOI      = 6'h05;
  localparam logic [ADDR_W-1:0] A_SPUR     = 6'h06;
  localparam logic [ADDR_W-1:0] A_LEVEL    = 6'h07;

  localparam logic [1:0] PAGE_CFG = 2'b01;
  localparam logic [1:0] PAGE_VEC = 2'b10;

endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ivc_detect.sv
module ivc_detect
  import ivc_pkg::*;
#(
  parameter int N_INT = 5,
  parameter int N_EXT = 3,
  localparam int NSRC = N_INT + N_EXT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      raw,
  input  src_cfg_t [NSRC-1:0]  cfg,
  input  logic [NSRC-1:0]      clr,
  output logic [NSRC-1:0]      pend
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic pol;
    logic prev_q;
    logic latch_q;
    logic act_now;
    logic act_prev;
    logic hit;

    // Internal sources have a fixed sense; external ones honour inversion
    if (i >= N_INT) begin : g_ext
      assign pol = cfg[i].invert;
    end else begin : g_int
      assign pol = 1'b0;
    end

    assign act_now  = raw[i] ^ pol;
    assign act_prev = prev_q ^ pol;
    assign hit      = act_now & ~act_prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= raw[i];
        if (!cfg[i].edge_mode)
          latch_q <= 1'b0;
        else if (hit)
          latch_q <= 1'b1;
        else if (clr[i])
          latch_q <= 1'b0;
      end
    end

    assign pend[i] = cfg[i].edge_mode ? latch_q : act_now;
  end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]     req,
  input  src_cfg_t [NSRC-1:0] cfg,
  output logic                win_valid,
  output logic [IDW-1:0]      win_id,
  output prio_t               win_prio
);

  // Scan from the top index down; ">=" lets a lower index take ties
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && (!win_valid || cfg[i].prio >= win_prio)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = cfg[i].prio;
      end
    end
  end

endmodule

// File: rtl/ivc_prio_stack.sv
module ivc_prio_stack
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  prio_t              push_prio,
  input  logic               pop,
  output logic [DEPTH_W-1:0] depth,
  output prio_t              top,
  output logic               empty
);

  localparam int IW = $clog2(N_LEVELS);

  prio_t              lvl [N_LEVELS];
  logic [DEPTH_W-1:0] dm1;
  logic               do_push;
  logic               do_pop;
  logic               do_swap;

  assign empty   = (depth == '0);
  assign dm1     = depth - 1'b1;
  assign do_swap = push && pop && !empty;
  assign do_push = push && !do_swap && (depth < DEPTH_W'(N_LEVELS));
  assign do_pop  = pop && !push && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       depth <= '0;
    else if (do_push) depth <= depth + 1'b1;
    else if (do_pop)  depth <= dm1;
  end

  always_ff @(posedge clk) begin
    if (do_push)      lvl[depth[IW-1:0]] <= push_prio;
    else if (do_swap) lvl[dm1[IW-1:0]]   <= push_prio;
  end

  assign top = empty ? '0 : lvl[dm1[IW-1:0]];

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int N_INT       = 5,
  parameter int N_EXT       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  int_src_i,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic              fast_req_i,
  input  logic [5:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int NSRC = N_INT + N_EXT;
  localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1;

  // ---------------- synchronised pins ----------------
  logic [N_EXT-1:0] ext_s;
  logic             fast_s;

  ivc_sync #(.W(N_EXT + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fast_req_i, ext_irq_i}),
    .q     ({fast_s, ext_s})
  );

  // ---------------- registers ----------------
  logic [NSRC-1:0]     mask_q;
  src_cfg_t [NSRC-1:0] cfg_q;
  logic [DATA_W-1:0]   vec_q [NSRC];
  logic [DATA_W-1:0]   spur_q;

  logic [1:0] page;
  logic [3:0] idx;
  assign page = bus_addr_i[5:4];
  assign idx  = bus_addr_i[3:0];

  // ---------------- detection and arbitration ----------------
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr;
  logic            win_valid;
  logic [IDW-1:0]  win_id;
  prio_t           win_prio;

  ivc_detect #(.N_INT(N_INT), .N_EXT(N_EXT)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({ext_s, int_src_i}),
    .cfg   (cfg_q),
    .clr   (clr),
    .pend  (pend)
  );

  ivc_arbiter #(.NSRC(NSRC)) u_arb (
    .req       (pend & mask_q),
    .cfg       (cfg_q),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_prio  (win_prio)
  );

  // ---------------- level stack ----------------
  logic [DEPTH_W-1:0] stk_depth;
  prio_t              stk_top;
  logic               stk_empty;
  logic               ack;
  logic               eoi;

  assign irq_o = win_valid && (stk_empty || win_prio > stk_top);
  assign fiq_o = fast_s;
  assign ack   = bus_re_i && (bus_addr_i == A_VEC) && irq_o;
  assign eoi   = bus_we_i && (bus_addr_i == A_EOI);

  always_comb begin
    clr = '0;
    for (int i = 0; i < NSRC; i++)
      if (ack && win_id == IDW'(i)) clr[i] = 1'b1;
  end

  ivc_prio_stack u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack),
    .push_prio (win_prio),
    .pop       (eoi),
    .depth     (stk_depth),
    .top       (stk_top),
    .empty     (stk_empty)
  );

  // ---------------- register writes ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cfg_q  <= '0;
      spur_q <= '0;
      for (int i = 0; i < NSRC; i++) vec_q[i] <= '0;
    end else if (bus_we_i) begin
      if (bus_addr_i == A_MASK_SET) mask_q <= mask_q | bus_wdata_i[NSRC-1:0];
      if (bus_addr_i == A_MASK_CLR) mask_q <= mask_q & ~bus_wdata_i[NSRC-1:0];
      if (bus_addr_i == A_SPUR)     spur_q <= bus_wdata_i;
      for (int i = 0; i < NSRC; i++) begin
        if (page == PAGE_CFG && idx == 4'(i)) cfg_q[i] <= src_cfg_t'(bus_wdata_i[CFG_W-1:0]);
        if (page == PAGE_VEC && idx == 4'(i)) vec_q[i] <= bus_wdata_i;
      end
    end
  end

  // ---------------- register reads ----------------
  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      case (bus_addr_i)
        A_MASK_SET, A_MASK_CLR, A_MASK: bus_rdata_o[NSRC-1:0] = mask_q;
        A_PEND:  bus_rdata_o[NSRC-1:0] = pend;
        A_SPUR:  bus_rdata_o = spur_q;
        A_LEVEL: begin
          bus_rdata_o[DEPTH_W-1:0]      = stk_depth;
          bus_rdata_o[DEPTH_W +: PRIO_W] = stk_top;
        end
        A_VEC: begin
          bus_rdata_o = spur_q;
          for (int i = 0; i < NSRC; i++)
            if (irq_o && win_id == IDW'(i)) bus_rdata_o = vec_q[i];
        end
        default: begin
          for (int i = 0; i < NSRC; i++) begin
            if (page == PAGE_CFG && idx == 4'(i)) bus_rdata_o[CFG_W-1:0] = cfg_q[i];
            if (page == PAGE_VEC && idx == 4'(i)) bus_rdata_o = vec_q[i];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int NSRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fast_req_i,
  input logic               fiq_o,
  input logic               irq_o,
  input logic [NSRC-1:0]    pend,
  input logic [NSRC-1:0]    mask_q,
  input logic               ack,
  input logic               eoi,
  input prio_t              win_prio,
  input logic [DEPTH_W-1:0] stk_depth,
  input prio_t              stk_top,
  input logic               stk_empty
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= DEPTH_W'(N_LEVELS)); // R12

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend & mask_q) != '0)); // R2

  AST_FIQ_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(fast_req_i, 2)); // R3

  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi) |=> stk_depth == $past(stk_depth) + 1'b1); // R7

  AST_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !stk_empty) |=> stk_depth == $past(stk_depth) - 1'b1); // R10

  AST_STACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !eoi) |=> $stable(stk_depth)); // R10

  AST_NEST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !stk_empty) |-> win_prio > stk_top); // R9

endmodule

bind irq_vector_ctrl ivc_checker #(.NSRC(NSRC)) u_ivc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fast_req_i (fast_req_i),
  .fiq_o      (fiq_o),
  .irq_o      (irq_o),
  .pend       (pend),
  .mask_q     (mask_q),
  .ack        (ack),
  .eoi        (eoi),
  .win_prio   (win_prio),
  .stk_depth  (stk_depth),
  .stk_top    (stk_top),
  .stk_empty  (stk_empty)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;

  localparam int N_INT = 5;
  localparam int N_EXT = 3;
  localparam int NSRC  = N_INT + N_EXT;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_INT-1:0] int_src = '0;
  logic [N_EXT-1:0] ext_irq = '0;
  logic             fast_req = 1'b0;
  logic [5:0]       addr = '0;
  logic             we = 1'b0;
  logic             re = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             irq;
  logic             fiq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT)) dut (
    .clk (clk), .rst_n (rst_n), .int_src_i (int_src), .ext_irq_i (ext_irq),
    .fast_req_i (fast_req), .bus_addr_i (addr), .bus_we_i (we), .bus_re_i (re),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq), .fiq_o (fiq)
  );

  function automatic logic [31:0] vexp(input int i);
    return 32'h0000_1000 + 32'(i) * 32'h100;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at posedge+1
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #3 d = rdata;
    step(1);
    re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic probe_irq(input string req, input logic exp);
    #3 check(req, {31'b0, irq}, {31'b0, exp});
    step(1);
  endtask

  task automatic set_src(input int i, input logic v);
    if (i < N_INT) int_src[i] = v;
    else ext_irq[i - N_INT] = v;
  endtask

  task automatic t_reset;
    #3 check("R1 irq_o low", {31'b0, irq}, 32'h0);
    check("R1 fiq_o low", {31'b0, fiq}, 32'h0);
    step(1);
    rd_chk("R1 mask reset", 6'h02, 32'h0);
    rd_chk("R1 level reset", 6'h07, 32'h0);
  endtask

  task automatic t_fast;
    wr(6'h10, 32'h0000_0007);
    wr(6'h00, 32'h0000_0001);
    int_src[0] = 1'b1;
    fast_req = 1'b1;
    step(3);
    #3 check("R3 fiq follows pin", {31'b0, fiq}, 32'h1);
    step(1);
    fast_req = 1'b0;
    step(3);
    #3 check("R3 fiq drops with pin while source active", {31'b0, fiq}, 32'h0);
    step(1);
    int_src[0] = 1'b0;
    wr(6'h01, 32'hFF);
    wr(6'h10, 32'h0);
  endtask

  task automatic t_mask;
    wr(6'h10, 32'h0000_0003);
    int_src[0] = 1'b1;
    step(1);
    probe_irq("R2 masked source silent", 1'b0);
    rd_chk("R2 masked source still pending", 6'h03, 32'h01);
    wr(6'h00, 32'h01);
    probe_irq("R2 unmasked source raises irq", 1'b1);
    wr(6'h00, 32'h00);
    rd_chk("R2 set with zero no effect", 6'h02, 32'h01);
    wr(6'h01, 32'h00);
    rd_chk("R2 clear with zero no effect", 6'h02, 32'h01);
    wr(6'h01, 32'h01);
    probe_irq("R2 cleared mask silences", 1'b0);
  endtask

  task automatic t_level_ack;
    wr(6'h00, 32'h01);
    rd_chk("R7 vector of src0", 6'h04, vexp(0));
    rd_chk("R7 level after ack", 6'h07, 32'h31);
    probe_irq("R9 equal level does not preempt", 1'b0);
    rd_chk("R8 level source stays pending", 6'h03, 32'h01);
    wr(6'h05, 32'h0);
    rd_chk("R10 eoi pops", 6'h07, 32'h0);
    probe_irq("R8 level source re-raises after eoi", 1'b1);
    int_src[0] = 1'b0;
    step(1);
    probe_irq("R8 level source gone", 1'b0);
    wr(6'h01, 32'hFF);
  endtask

  task automatic t_int_edge;
    int_src[1] = 1'b1;
    step(2);
    wr(6'h11, 32'h0000_001A);
    wr(6'h00, 32'h02);
    int_src[1] = 1'b0;
    step(2);
    probe_irq("R4 internal ignores invert, no falling trigger", 1'b0);
    int_src[1] = 1'b1;
    step(1);
    int_src[1] = 1'b0;
    step(1);
    probe_irq("R4 internal rising edge latched", 1'b1);
    rd_chk("R7 vector of src1", 6'h04, vexp(1));
    rd_chk("R7 edge latch cleared by ack", 6'h03, 32'h00);
    wr(6'h05, 32'h0);
    wr(6'h01, 32'hFF);
  endtask

  task automatic t_ext_modes;
    // rising edge on source 5
    wr(6'h15, 32'h0000_000C);
    wr(6'h00, 32'h20);
    ext_irq[0] = 1'b1;
    step(4);
    probe_irq("R5 external rising edge", 1'b1);
    rd_chk("R5 vector of src5", 6'h04, vexp(5));
    rd_chk("R5 edge cleared while pin high", 6'h03, 32'h00);
    wr(6'h05, 32'h0);
    ext_irq[0] = 1'b0;
    wr(6'h01, 32'hFF);
    // falling edge on source 6
    ext_irq[1] = 1'b1;
    step(4);
    wr(6'h16, 32'h0000_001A);
    wr(6'h00, 32'h40);
    step(2);
    probe_irq("R5 falling mode quiet while high", 1'b0);
    ext_irq[1] = 1'b0;
    step(4);
    probe_irq("R5 external falling edge", 1'b1);
    rd_chk("R5 vector of src6", 6'h04, vexp(6));
    wr(6'h05, 32'h0);
    wr(6'h01, 32'hFF);
    // low level on source 7
    wr(6'h17, 32'h0000_0011);
    wr(6'h00, 32'h80);
    probe_irq("R5 low level active at 0", 1'b1);
    ext_irq[2] = 1'b1;
    step(4);
    probe_irq("R5 low level inactive at 1", 1'b0);
    wr(6'h17, 32'h0000_0001);
    probe_irq("R5 high level active at 1", 1'b1);
    ext_irq[2] = 1'b0;
    step(4);
    probe_irq("R5 high level inactive at 0", 1'b0);
    wr(6'h01, 32'hFF);
  endtask

  task automatic t_priority;
    wr(6'h12, 32'h0000_000D);
    wr(6'h13, 32'h0000_000D);
    wr(6'h14, 32'h0000_000E);
    wr(6'h00, 32'h1C);
    int_src[4:2] = 3'b111;
    step(1);
    int_src[4:2] = 3'b000;
    step(1);
    rd_chk("R6 highest priority wins", 6'h04, vexp(4));
    probe_irq("R9 lower priority waits", 1'b0);
    wr(6'h05, 32'h0);
    probe_irq("R9 waiting source raises after eoi", 1'b1);
    rd_chk("R6 tie goes to lowest number", 6'h04, vexp(2));
    wr(6'h05, 32'h0);
    rd_chk("R6 remaining tied source", 6'h04, vexp(3));
    wr(6'h05, 32'h0);
    probe_irq("R7 all latches cleared", 1'b0);
    wr(6'h01, 32'hFF);
  endtask

  task automatic t_nest_spur;
    wr(6'h10, 32'h0000_0001);
    wr(6'h00, 32'h11);
    int_src[0] = 1'b1;
    step(1);
    rd_chk("R7 outer vector", 6'h04, vexp(0));
    rd_chk("R7 outer level", 6'h07, 32'h11);
    int_src[4] = 1'b1;
    step(1);
    int_src[4] = 1'b0;
    step(1);
    probe_irq("R9 higher priority preempts", 1'b1);
    rd_chk("R7 nested vector", 6'h04, vexp(4));
    rd_chk("R7 nested level", 6'h07, 32'h62);
    wr(6'h05, 32'h0);
    rd_chk("R10 pop returns to outer", 6'h07, 32'h11);
    probe_irq("R9 outer level source held off", 1'b0);
    int_src[0] = 1'b0;
    wr(6'h05, 32'h0);
    rd_chk("R10 stack empty", 6'h07, 32'h00);
    wr(6'h06, 32'hDEAD_BEEF);
    rd_chk("R11 spurious vector", 6'h04, 32'hDEAD_BEEF);
    rd_chk("R11 no push on spurious", 6'h07, 32'h00);
    wr(6'h05, 32'h0);
    rd_chk("R10 eoi on empty ignored", 6'h07, 32'h00);
    wr(6'h01, 32'hFF);
  endtask

  task automatic t_full_stack;
    for (int i = 0; i < NSRC; i++) wr(6'h10 + 6'(i), 32'(i));
    wr(6'h00, 32'hFF);
    for (int i = 0; i < NSRC; i++) begin
      set_src(i, 1'b1);
      step(4);
      rd_chk("R12 nested ack in rising order", 6'h04, vexp(i));
    end
    rd_chk("R12 full stack level", 6'h07, 32'h78);
    probe_irq("R12 nothing preempts top level", 1'b0);
    rd_chk("R12 spurious on full stack", 6'h04, 32'hDEAD_BEEF);
    rd_chk("R12 depth unchanged", 6'h07, 32'h78);
    for (int i = 0; i < NSRC; i++) wr(6'h05, 32'h0);
    rd_chk("R10 stack drained", 6'h07, 32'h00);
    int_src = '0;
    ext_irq = '0;
    wr(6'h01, 32'hFF);
  endtask

  task automatic t_readback;
    addr = 6'h02; re = 1'b1;
    #3 check("R13 read data same cycle", rdata, 32'h0);
    step(1);
    re = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    for (int i = 0; i < NSRC; i++) wr(6'h20 + 6'(i), vexp(i));
    t_reset();
    t_fast();
    t_mask();
    t_level_ack();
    t_int_edge();
    t_ext_modes();
    t_priority();
    t_nest_spur();
    t_full_stack();
    t_readback();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule